// File: doc/BRIEF.md
# Gigabit Ethernet PCS Frame Sequencer

This block sits on the transmit path in front of an 8b/10b PCS and drives a byte-wide data lane with a K-character flag. Between frames it sends the idle ordered set. When a frame may start, it sends the start code, the preamble and the SFD. It then fetches a fixed-length frame body one byte per cycle through a read-request strobe and forwards four FCS bytes taken from an input word. It closes the frame with the end delimiter, plus a carrier-extend byte when the body length is odd.

Header assembly, CRC computation and payload storage live upstream. The upstream side supplies a level count of buffered body bytes, the body bytes themselves after a fixed read latency of 0 to 2 cycles, and the FCS word. The PCS supplies its current running disparity. The block raises a one-cycle disparity-fix pulse when a gap opens and a one-cycle done pulse when a frame ends, and it keeps a wrapping count of frames sent.

Top module: `gbe_frame_seq`

## Requirements
- R1: While reset is held and right after it, the block is in the gap: `tx_data`=0xBC with `tx_k`=1, `rd_req`, `pkt_done` and `disp_fix` are low, and `pkt_count` is 0.
- R2: In the gap, bytes come in pairs: an even byte 0xBC with `tx_k`=1, then an odd byte 0x50 with `tx_k`=0. Every gap starts on an even byte.
- R3: If `pcs_rd_pos` is high during the first byte of a gap, the second byte of that gap is 0xC5 (data) instead of 0x50. All later pairs use 0x50.
- R4: A frame begins in the cycle right after a cycle in which all of these hold: the odd byte of a pair is on the lane, this is at least the 12th gap byte, and `body_level` >= BODY_LEN. In any other case the gap continues.
- R5: A frame opens with 0xFB (`tx_k`=1), then six 0x55 bytes, then 0xD5, all with `tx_k`=0 apart from the first.
- R6: Exactly BODY_LEN body bytes follow the SFD back to back with `tx_k`=0, in the order they were requested. `rd_req` is high for exactly BODY_LEN cycles per frame. It starts RD_LAT cycles before the first body byte, and `body_data` is taken RD_LAT cycles after its request.
- R7: After the body come four data bytes of `fcs_word`, least significant byte first (bits 7:0, then 15:8, 23:16, 31:24).
- R8: After the FCS, the block sends 0xFD then 0xF7, both with `tx_k`=1.
- R9: When BODY_LEN is odd, one further 0xF7 (`tx_k`=1) follows before the gap. When it is even, the gap follows at once.
- R10: `disp_fix` is high for exactly the first cycle of each gap that follows a frame, and never in the gap that follows reset.
- R11: `pkt_done` is high in the cycle the 0xF7 following 0xFD is on the lane, and only then. `pkt_count` rises by one in the next cycle, wrapping modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCS transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| body_level | input | LVL_W | Body bytes available upstream |
| body_data | input | 8 | Body byte returned RD_LAT cycles after its request |
| fcs_word | input | 32 | Frame check sequence, sent low byte first |
| pcs_rd_pos | input | 1 | PCS running disparity is positive |
| rd_req | output | 1 | Request for one body byte |
| tx_data | output | 8 | Byte to the PCS |
| tx_k | output | 1 | `tx_data` is a K character |
| disp_fix | output | 1 | First cycle of a gap after a frame |
| pkt_done | output | 1 | Frame end pulse |
| pkt_count | output | CNT_W | Frames sent, wrapping |

## Verification
The bench builds two copies side by side. The first has a five-byte body, a read latency of 2 and a 3-bit frame counter, so odd-length padding, the earliest possible read requests and several counter wraps all occur within a short run. The second has an eight-byte body and zero read latency, which covers the even-length ending and a request issued in the same cycle as its byte. In both copies, the random level input often sits just under or exactly at the body length and the disparity input changes every cycle, so the start gating is hit at the 12-byte boundary and in longer gaps.

// File: rtl/gfs_pkg.sv
package gfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_BODY, ST_FCS, ST_END, ST_EXT
  } seq_state_t;

  localparam logic [7:0] K_IDLE  = 8'hBC;
  localparam logic [7:0] D_IDLE2 = 8'h50;
  localparam logic [7:0] D_IDLE1 = 8'hC5;
  localparam logic [7:0] K_SOP   = 8'hFB;
  localparam logic [7:0] D_PRE   = 8'h55;
  localparam logic [7:0] D_SFD   = 8'hD5;
  localparam logic [7:0] K_EOP   = 8'hFD;
  localparam logic [7:0] K_EXT   = 8'hF7;

  localparam int PRE_LEN = 8;
  localparam int FCS_LEN = 4;
  localparam int END_LEN = 2;

  // Bits of the per-segment byte index: must hold the longer of preamble and body.
  function automatic int idx_width(input int body_len);
    return $clog2(body_len > PRE_LEN ? body_len : PRE_LEN);
  endfunction

  // Length of the segment a state spans.
  function automatic int seg_len(input seq_state_t st, input int body_len);
    case (st)
      ST_PRE:  return PRE_LEN;
      ST_BODY: return body_len;
      ST_FCS:  return FCS_LEN;
      ST_END:  return END_LEN;
      ST_EXT:  return 1;
      default: return 0;
    endcase
  endfunction

  // A read is issued lat cycles ahead of the byte slot it feeds.
  function automatic logic rd_window(input seq_state_t st, input int idx,
                                     input int body_len, input int lat);
    return (st == ST_PRE  && idx >= PRE_LEN - lat) ||
           (st == ST_BODY && idx + lat < body_len);
  endfunction

endpackage

// File: rtl/gfs_idle_gen.sv
module gfs_idle_gen #(
  parameter int MIN_IDLE = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       pcs_rd_pos,
  output logic [7:0] idle_data,
  output logic       idle_k,
  output logic       gap_ready
);
  import gfs_pkg::*;

  localparam int CW = $clog2(MIN_IDLE + 1);

  logic          phase;
  logic [CW-1:0] cnt;
  logic          fix_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= 1'b0;
      cnt         <= '0;
      fix_pending <= 1'b0;
    end else if (!active) begin
      phase <= 1'b0;
      cnt   <= '0;
    end else begin
      phase <= ~phase;
      if (cnt != CW'(MIN_IDLE)) cnt <= cnt + 1'b1;
      if (cnt == '0) fix_pending <= pcs_rd_pos;
    end
  end

  assign idle_k    = ~phase;
  assign idle_data = !phase ? K_IDLE :
                     (fix_pending && cnt == CW'(1)) ? D_IDLE1 : D_IDLE2;
  // Odd byte of a pair with at least MIN_IDLE bytes sent once it completes.
  assign gap_ready = active && phase && (cnt >= CW'(MIN_IDLE - 1));

endmodule

// File: rtl/gfs_ctrl.sv
module gfs_ctrl #(
  parameter int BODY_LEN = 46,
  parameter int RD_LAT   = 2,
  parameter int LVL_W    = 12,
  parameter int CNT_W    = 16,
  parameter int IW       = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gap_ready,
  input  logic [LVL_W-1:0]    body_level,
  output gfs_pkg::seq_state_t state,
  output logic [IW-1:0]       idx,
  output logic                rd_req,
  output logic                start_evt,
  output logic                pkt_done,
  output logic                disp_fix,
  output logic [CNT_W-1:0]    pkt_count
);
  import gfs_pkg::*;

  localparam bit ODD_BODY = (BODY_LEN % 2) == 1;

  seq_state_t next_state;
  logic       seg_last;

  assign start_evt = (state == ST_IDLE) && gap_ready &&
                     (body_level >= LVL_W'(BODY_LEN));
  assign seg_last  = (int'(idx) == seg_len(state, BODY_LEN) - 1);

  always_comb begin
    next_state = state;
    case (state)
      ST_IDLE: if (start_evt) next_state = ST_PRE;
      ST_PRE:  if (seg_last)  next_state = ST_BODY;
      ST_BODY: if (seg_last)  next_state = ST_FCS;
      ST_FCS:  if (seg_last)  next_state = ST_END;
      ST_END:  if (seg_last)  next_state = ODD_BODY ? ST_EXT : ST_IDLE;
      ST_EXT:  next_state = ST_IDLE;
      default: next_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      disp_fix  <= 1'b0;
      pkt_count <= '0;
    end else begin
      state    <= next_state;
      idx      <= (next_state != state || state == ST_IDLE) ? '0 : idx + 1'b1;
      disp_fix <= (next_state == ST_IDLE) && (state != ST_IDLE);
      if (pkt_done) pkt_count <= pkt_count + 1'b1;
    end
  end

  assign pkt_done = (state == ST_END) && (idx == IW'(1));
  assign rd_req   = rd_window(state, int'(idx), BODY_LEN, RD_LAT);

endmodule

// File: rtl/gfs_out_mux.sv
module gfs_out_mux #(
  parameter int IW = 6
) (
  input  gfs_pkg::seq_state_t state,
  input  logic [IW-1:0]       idx,
  input  logic [7:0]          idle_data,
  input  logic                idle_k,
  input  logic [7:0]          body_data,
  input  logic [31:0]         fcs_word,
  output logic [7:0]          tx_data,
  output logic                tx_k
);
  import gfs_pkg::*;

  always_comb begin
    tx_k    = 1'b0;
    tx_data = 8'h00;
    case (state)
      ST_PRE: begin
        if (idx == '0) begin
          tx_k    = 1'b1;
          tx_data = K_SOP;
        end else begin
          tx_data = (idx == IW'(PRE_LEN - 1)) ? D_SFD : D_PRE;
        end
      end
      ST_BODY: tx_data = body_data;
      ST_FCS:  tx_data = 8'(fcs_word >> {idx[1:0], 3'b000});
      ST_END: begin
        tx_k    = 1'b1;
        tx_data = (idx == '0) ? K_EOP : K_EXT;
      end
      ST_EXT: begin
        tx_k    = 1'b1;
        tx_data = K_EXT;
      end
      default: begin
        tx_k    = idle_k;
        tx_data = idle_data;
      end
    endcase
  end

endmodule

// File: rtl/gbe_frame_seq.sv
module gbe_frame_seq #(
  parameter int BODY_LEN = 46,
  parameter int RD_LAT   = 2,
  parameter int LVL_W    = 12,
  parameter int CNT_W    = 16,
  parameter int MIN_IDLE = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] body_level,
  input  logic [7:0]       body_data,
  input  logic [31:0]      fcs_word,
  input  logic             pcs_rd_pos,
  output logic             rd_req,
  output logic [7:0]       tx_data,
  output logic             tx_k,
  output logic             disp_fix,
  output logic             pkt_done,
  output logic [CNT_W-1:0] pkt_count
);
  import gfs_pkg::*;

  localparam int IW = idx_width(BODY_LEN);

  seq_state_t    state;
  logic [IW-1:0] idx;
  logic [7:0]    idle_data;
  logic          idle_k;
  logic          gap_ready;
  logic          start_evt;
  logic          in_gap;

  assign in_gap = (state == ST_IDLE);

  gfs_idle_gen #(.MIN_IDLE(MIN_IDLE)) u_idle (
    .clk(clk), .rst_n(rst_n), .active(in_gap), .pcs_rd_pos(pcs_rd_pos),
    .idle_data(idle_data), .idle_k(idle_k), .gap_ready(gap_ready)
  );

  gfs_ctrl #(
    .BODY_LEN(BODY_LEN), .RD_LAT(RD_LAT), .LVL_W(LVL_W), .CNT_W(CNT_W), .IW(IW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .gap_ready(gap_ready), .body_level(body_level),
    .state(state), .idx(idx), .rd_req(rd_req), .start_evt(start_evt),
    .pkt_done(pkt_done), .disp_fix(disp_fix), .pkt_count(pkt_count)
  );

  gfs_out_mux #(.IW(IW)) u_mux (
    .state(state), .idx(idx), .idle_data(idle_data), .idle_k(idle_k),
    .body_data(body_data), .fcs_word(fcs_word), .tx_data(tx_data), .tx_k(tx_k)
  );

endmodule

// File: rtl/gfs_checks.sv
module gfs_checks #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       tx_data,
  input logic             tx_k,
  input logic             disp_fix,
  input logic             pkt_done,
  input logic [CNT_W-1:0] pkt_count,
  input logic             start_evt
);

  assert_fix_on_idle_K_R10: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fix |-> (tx_k && tx_data == 8'hBC));

  assert_fix_done_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_fix && pkt_done));

  assert_done_after_eop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (tx_k && tx_data == 8'hF7 && $past(tx_k) && $past(tx_data) == 8'hFD));

  assert_count_bump_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> (pkt_count == $past(pkt_count) + 1'b1));

  assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_done |=> $stable(pkt_count));

  assert_start_on_odd_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> (!tx_k && (tx_data == 8'h50 || tx_data == 8'hC5)));

  assert_sop_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (tx_k && tx_data == 8'hFB));

endmodule

bind gbe_frame_seq gfs_checks #(.CNT_W(CNT_W)) u_gfs_checks (
  .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_k(tx_k),
  .disp_fix(disp_fix), .pkt_done(pkt_done), .pkt_count(pkt_count),
  .start_evt(start_evt)
);

// File: tb/gfs_lane.sv
module gfs_lane #(
  parameter int BODY_LEN = 5,
  parameter int RD_LAT   = 2,
  parameter int CNT_W    = 3
) (
  input  logic clk,
  input  logic rst_n,
  output int   checks,
  output int   errors,
  output int   frames
);
  localparam int LVL_W = 8;

  logic [LVL_W-1:0] level;
  logic [7:0]       body_data;
  logic [31:0]      fcs_word;
  logic             pcs_rd_pos;
  logic             rd_req;
  logic [7:0]       tx_data;
  logic             tx_k;
  logic             disp_fix;
  logic             pkt_done;
  logic [CNT_W-1:0] pkt_count;

  gbe_frame_seq #(.BODY_LEN(BODY_LEN), .RD_LAT(RD_LAT), .LVL_W(LVL_W), .CNT_W(CNT_W))
  u_gbe_frame_seq (
    .clk(clk), .rst_n(rst_n), .body_level(level), .body_data(body_data),
    .fcs_word(fcs_word), .pcs_rd_pos(pcs_rd_pos), .rd_req(rd_req),
    .tx_data(tx_data), .tx_k(tx_k), .disp_fix(disp_fix),
    .pkt_done(pkt_done), .pkt_count(pkt_count)
  );

  function automatic logic [7:0] pat(input int n);
    return 8'((n * 29 + 7) ^ (n >> 3));
  endfunction

  // Upstream source model with RD_LAT cycles of read latency.
  int         rcount;
  logic [7:0] p1, p2;
  assign body_data = (RD_LAT == 0) ? pat(rcount) : (RD_LAT == 1) ? p1 : p2;

  initial begin
    rcount = 0; p1 = 8'h00; p2 = 8'h00;
    forever begin
      @(posedge clk);
      if (rd_req) begin
        p1     <= pat(rcount);
        rcount <= rcount + 1;
      end
      p2 <= p1;
    end
  end

  // Stimulus: level held just short of a body at first, then random.
  initial begin
    level = LVL_W'(BODY_LEN - 1); pcs_rd_pos = 1'b0; fcs_word = 32'h0;
    @(posedge rst_n);
    for (int c = 0; ; c++) begin
      @(posedge clk); #1;
      pcs_rd_pos = 1'($urandom % 2);
      fcs_word   = $urandom;
      if (c >= 60) begin
        int r;
        r = int'($urandom % 8);
        if (r < 2)       level = LVL_W'(BODY_LEN - 1);
        else if (r == 2) level = '0;
        else if (r == 3) level = LVL_W'(BODY_LEN);
        else             level = LVL_W'(BODY_LEN + r);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s lane L%0d: actual 0x%0h expected 0x%0h at %0t",
               req, BODY_LEN, act, exp, $time);
    end
  endtask

  // Stream parser: expected behaviour restated from the requirements.
  initial begin
    int ps, pi, gcnt, bcount, exp_cnt;
    bit phase, fixexp, after_frame, prev_pair, prev_ok, exp_rd, exp_done, exp_fix;
    checks = 0; errors = 0; frames = 0;
    ps = 0; pi = 0; gcnt = 0; bcount = 0; exp_cnt = 0;
    phase = 0; fixexp = 0; after_frame = 0; prev_pair = 0; prev_ok = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        chk(tx_k && tx_data == 8'hBC, "R1 idle byte", {tx_k, tx_data}, 9'h1BC);
        chk(!rd_req && !pkt_done && !disp_fix, "R1 strobes", {rd_req, pkt_done, disp_fix}, 0);
        chk(pkt_count == '0, "R1 count", int'(pkt_count), 0);
        ps = 0; gcnt = 0; phase = 0; after_frame = 0; prev_pair = 0; exp_cnt = 0;
      end else begin
        exp_done = 0; exp_fix = 0;
        if (ps == 0 && !phase && prev_pair && prev_ok) begin
          ps = 1; pi = 0;
        end
        case (ps)
          0: begin
            exp_fix = (gcnt == 0) && after_frame;
            if (gcnt == 0) fixexp = pcs_rd_pos;
            if (!phase)
              chk(tx_k && tx_data == 8'hBC, "R2/R4 gap even byte", {tx_k, tx_data}, 9'h1BC);
            else if (gcnt == 1 && fixexp)
              chk(!tx_k && tx_data == 8'hC5, "R3 correction byte", {tx_k, tx_data}, 9'h0C5);
            else
              chk(!tx_k && tx_data == 8'h50, "R2 gap odd byte", {tx_k, tx_data}, 9'h050);
            prev_pair = phase && gcnt >= 11;
            gcnt++; phase = !phase;
          end
          1: begin
            prev_pair = 0;
            if (pi == 0)
              chk(tx_k && tx_data == 8'hFB, "R4/R5 start code", {tx_k, tx_data}, 9'h1FB);
            else if (pi == 7)
              chk(!tx_k && tx_data == 8'hD5, "R5 SFD", {tx_k, tx_data}, 9'h0D5);
            else
              chk(!tx_k && tx_data == 8'h55, "R5 preamble", {tx_k, tx_data}, 9'h055);
          end
          2: begin
            chk(!tx_k && tx_data == pat(bcount), "R6 body byte", {tx_k, tx_data}, int'(pat(bcount)));
            bcount++;
          end
          3: chk(!tx_k && tx_data == fcs_word[8*pi +: 8], "R7 FCS byte",
                 {tx_k, tx_data}, int'(fcs_word[8*pi +: 8]));
          4: begin
            if (pi == 0)
              chk(tx_k && tx_data == 8'hFD, "R8 end code", {tx_k, tx_data}, 9'h1FD);
            else begin
              chk(tx_k && tx_data == 8'hF7, "R8 extend", {tx_k, tx_data}, 9'h1F7);
              exp_done = 1;
            end
          end
          default: chk(tx_k && tx_data == 8'hF7, "R9 odd pad", {tx_k, tx_data}, 9'h1F7);
        endcase
        exp_rd = (ps == 1 && pi >= 8 - RD_LAT) || (ps == 2 && pi + RD_LAT < BODY_LEN);
        chk(rd_req == exp_rd, "R6 read request", int'(rd_req), int'(exp_rd));
        chk(pkt_done == exp_done, "R11 done pulse", int'(pkt_done), int'(exp_done));
        chk(disp_fix == exp_fix, "R10 fix pulse", int'(disp_fix), int'(exp_fix));
        chk(pkt_count == CNT_W'(exp_cnt), "R11 count", int'(pkt_count), exp_cnt % (1 << CNT_W));
        if (exp_done) begin
          exp_cnt++; frames++;
        end
        prev_ok = (int'(level) >= BODY_LEN);
        // advance segment position
        if (ps != 0) begin
          pi++;
          if (ps == 1 && pi == 8) begin ps = 2; pi = 0; end
          else if (ps == 2 && pi == BODY_LEN) begin ps = 3; pi = 0; end
          else if (ps == 3 && pi == 4) begin ps = 4; pi = 0; end
          else if (ps == 4 && pi == 2) begin
            pi = 0;
            if (BODY_LEN % 2 == 1) ps = 5;
            else begin ps = 0; gcnt = 0; phase = 0; after_frame = 1; end
          end else if (ps == 5) begin
            ps = 0; gcnt = 0; phase = 0; after_frame = 1;
          end
        end
      end
    end
  end

endmodule

// File: tb/gbe_frame_seq_bench.sv
module gbe_frame_seq_bench;
  logic clk;
  logic rst_n;
  int   chk_o, err_o, frm_o;
  int   chk_e, err_e, frm_e;
  int   wd_err;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Odd body, latency 2, narrow wrapping counter (R9, R6, R11).
  gfs_lane #(.BODY_LEN(5), .RD_LAT(2), .CNT_W(3)) u_lane_odd (
    .clk(clk), .rst_n(rst_n), .checks(chk_o), .errors(err_o), .frames(frm_o));

  // Even body, zero latency.
  gfs_lane #(.BODY_LEN(8), .RD_LAT(0), .CNT_W(16)) u_lane_even (
    .clk(clk), .rst_n(rst_n), .checks(chk_e), .errors(err_e), .frames(frm_e));

  initial begin
    void'($urandom(32'd1234));
    wd_err = 0;
    rst_n  = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int c = 0; ; c++) begin
      @(posedge clk);
      if (frm_o >= 30 && frm_e >= 30) break;
      if (c >= 50000) begin
        wd_err = 1;
        $display("FAIL watchdog: actual frames %0d/%0d expected 30/30", frm_o, frm_e);
        break;
      end
    end
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", chk_o + chk_e + wd_err, err_o + err_e + wd_err);
    $finish;
  end

endmodule